// File: doc/BRIEF.md
# Programmable Watchdog Timer with 16-bit Register Port

This block is a watchdog timer that software reaches through a small 16-bit register port. Five registers hold control, the service key, the cause of the last reset, the pre-timeout interrupt setup and a misc storage bit. Once software enables it, the watchdog counts down in half-second units. Each unit is one cycle with `tick_en` high. If software does not write the two-word service key in time, the counter runs out. The block then asserts a held timeout reset and, if configured, pulls the external watchdog pin low. Software can also request a one-cycle software reset, and it can arm an interrupt that fires a programmable number of units before expiry.

The reset-cause register runs on its own power-on reset `por_n`, so it survives the system reset `rst_n` that a timeout causes. Three status inputs can pause the countdown, each gated by its own control bit: debug halt, low power and wait state.

Three state machines make up the block. The service-key machine has two states. `SVC_IDLE` moves to `SVC_ARMED` on a 0x5555 write. From `SVC_ARMED`, a 0xAAAA write reloads the counter and returns to `SVC_IDLE` (transition "service"), another 0x5555 write stays in `SVC_ARMED`, and any other value returns to `SVC_IDLE` (transition "abort"). The countdown machine has three states. `CNT_OFF` moves to `CNT_RUN` when the enable bit is first written (transition "start"). `CNT_RUN` stays in place on a reload or a tick, and moves to `CNT_DONE` on a tick taken at count zero (transition "expire"). `CNT_DONE` is left only through `rst_n`.

Top module: `wdog_top`

## Requirements
- R1: After reset, control (offset 0x0) reads 0x0030, interrupt control (0x6) reads 0x0000 and misc (0x8) reads 0x0001. After reset `tout_rst_o`, `sw_rst_o` and `irq_o` are 0 and `wdog_pin_n_o` is 1.
- R2: Control bit 2 enables the watchdog. Once it is written 1, a later write of 0 has no effect until `rst_n`, and the bit reads back as 1.
- R3: With timeout field N in control bits 15:8, `tout_rst_o` rises after the (N+1)-th unpaused tick following the load. It then stays high until `rst_n`.
- R4: Writing 0x5555 and then 0xAAAA to the service register (offset 0x2) reloads the counter with N.
- R5: A service write of any other value, or a 0xAAAA write with no 0x5555 before it, aborts the sequence, and no reload takes place.
- R6: A control write while the watchdog is enabled reloads the counter with the newly written timeout field.
- R7: Ticks are ignored while `dbg_halt_i` and control bit 1 are both high, while `low_pwr_i` and control bit 0 are both high, or while `wait_i` and control bit 7 are both high.
- R8: Interrupt-control bit 14 sets on the tick that makes the remaining count equal to bits 7:0. `irq_o` is high while bit 14 and bit 15 are both 1. Writing 1 to bit 14 clears it.
- R9: Writing 0 to control bit 4 (which reads as 1) gives a one-cycle `sw_rst_o` pulse and sets reset status (0x4) to 0x0001.
- R10: A timeout sets reset status to 0x0002. Reset status holds at most one cause bit, keeps its value across `rst_n`, and clears only on `por_n`.
- R11: `wdog_pin_n_o` is low while control bit 5 is 0, or while the watchdog has expired and control bit 3 is 1.
- R12: Misc bit 0 (power-down enable) holds the value last written to it and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| por_n | input | 1 | Power-on reset for the reset-cause register, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| tick_en | input | 1 | Half-second time base, one cycle per unit |
| dbg_halt_i | input | 1 | Debug halt status |
| low_pwr_i | input | 1 | Low-power status |
| wait_i | input | 1 | Wait-state status |
| tout_rst_o | output | 1 | Timeout reset, held after expiry |
| sw_rst_o | output | 1 | One-cycle software reset pulse |
| wdog_pin_n_o | output | 1 | External watchdog pin, active low |
| irq_o | output | 1 | Pre-timeout interrupt |

## Verification
The countdown is driven with plain runs of ticks and with runs interrupted by a correct key, by a corrupted key (a wrong middle word, or a lone 0xAAAA), and by a control rewrite. Expiry is checked one tick before the expected count and on it, which separates off-by-one loads and missed or false reloads. Ticks given under each pause condition, and under a status input whose control bit is clear, separate correct gating from gating that always or never applies. Interrupt timing, the reset-cause encoding and its survival across `rst_n`, and the pin conditions each get their own scenario.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 4;
    localparam int CNT_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_SVC  = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_RSR  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_ICR  = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_MISC = 4'h8;

    localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

    typedef enum logic {SVC_IDLE, SVC_ARMED} svc_state_t;
    typedef enum logic [1:0] {CNT_OFF, CNT_RUN, CNT_DONE} cnt_state_t;
endpackage

// File: rtl/wdog_svc.sv
module wdog_svc
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_wr,
    input  logic [REG_W-1:0] svc_data,
    output logic             svc_ok
);
    svc_state_t cur, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= SVC_IDLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        if (svc_wr) begin
            unique case (cur)
                SVC_IDLE:  nxt = (svc_data == KEY_FIRST) ? SVC_ARMED : SVC_IDLE;
                SVC_ARMED: nxt = (svc_data == KEY_FIRST) ? SVC_ARMED : SVC_IDLE;
                default:   nxt = SVC_IDLE;
            endcase
        end
    end

    always_comb begin
        svc_ok = svc_wr && (cur == SVC_ARMED) && (svc_data == KEY_SECOND);
    end

    // R5: an unexpected word while armed returns the sequence to its start
    assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == SVC_ARMED && svc_wr && svc_data != KEY_FIRST && svc_data != KEY_SECOND)
        |=> (cur == SVC_IDLE));
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
    import wdog_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         hold,
    input  logic         load,
    input  logic         wdog_on,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] pre_val,
    output logic         pre_hit,
    output logic         expire,
    output logic         expired
);
    cnt_state_t cur, nxt;
    logic [W-1:0] count_q, count_d;
    logic step;

    assign step = tick_en && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= CNT_OFF;
            count_q <= '0;
        end else begin
            cur     <= nxt;
            count_q <= count_d;
        end
    end

    always_comb begin
        nxt     = cur;
        count_d = count_q;
        unique case (cur)
            CNT_OFF: if (load && wdog_on) begin
                nxt     = CNT_RUN;
                count_d = load_val;
            end
            CNT_RUN: if (load) begin
                count_d = load_val;
            end else if (step) begin
                if (count_q == '0) nxt = CNT_DONE;
                else               count_d = count_q - 1'b1;
            end
            CNT_DONE: nxt = CNT_DONE;
            default:  nxt = CNT_OFF;
        endcase
    end

    always_comb begin
        expired = (cur == CNT_DONE);
        expire  = (cur == CNT_RUN) && !load && step && (count_q == '0);
        pre_hit = (cur == CNT_RUN) && !load && step && (count_q != '0)
                  && ((count_q - 1'b1) == pre_val);
    end

    // R7: without a tick that is allowed through, the count holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == CNT_RUN && !load && !step) |=> (count_q == $past(count_q)));
    // R3: expiry is held until reset
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == CNT_DONE) |=> (cur == CNT_DONE));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tick_en,
    input  logic              dbg_halt_i,
    input  logic              low_pwr_i,
    input  logic              wait_i,
    output logic              tout_rst_o,
    output logic              sw_rst_o,
    output logic              wdog_pin_n_o,
    output logic              irq_o
);
    localparam int TB_LO = 8;
    localparam int TB_HI = TB_LO + CNT_W - 1;

    logic wr_ctrl, wr_svc, wr_icr, wr_misc;
    logic lp_en_q, dbg_en_q, wde_q, wdt_q, wda_q, wdw_q, pde_q;
    logic [CNT_W-1:0] wt_q, wict_q;
    logic ie_q, ists_q, sw_rst_q;
    logic [1:0] rsr_q;
    logic wde_nx, svc_ok, load, hold, pre_hit, expire, expired;

    always_comb begin
        wr_ctrl = bus_sel && bus_we && bus_addr == OFS_CTRL;
        wr_svc  = bus_sel && bus_we && bus_addr == OFS_SVC;
        wr_icr  = bus_sel && bus_we && bus_addr == OFS_ICR;
        wr_misc = bus_sel && bus_we && bus_addr == OFS_MISC;
        wde_nx  = wde_q || (wr_ctrl && bus_wdata[2]);
        load    = (wr_ctrl && wde_nx) || svc_ok;
        hold    = (dbg_halt_i && dbg_en_q) || (low_pwr_i && lp_en_q) || (wait_i && wdw_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {lp_en_q, dbg_en_q, wde_q, wdt_q, wdw_q} <= '0;
            wda_q    <= 1'b1;
            pde_q    <= 1'b1;
            wt_q     <= '0;
            wict_q   <= '0;
            ie_q     <= 1'b0;
            ists_q   <= 1'b0;
            sw_rst_q <= 1'b0;
        end else begin
            sw_rst_q <= wr_ctrl && !bus_wdata[4];
            if (wr_ctrl) begin
                lp_en_q  <= bus_wdata[0];
                dbg_en_q <= bus_wdata[1];
                wde_q    <= wde_nx;
                wdt_q    <= bus_wdata[3];
                wda_q    <= bus_wdata[5];
                wdw_q    <= bus_wdata[7];
                wt_q     <= bus_wdata[TB_HI:TB_LO];
            end
            if (wr_icr) begin
                wict_q <= bus_wdata[CNT_W-1:0];
                ie_q   <= bus_wdata[15];
            end
            if (pre_hit)                    ists_q <= 1'b1;
            else if (wr_icr && bus_wdata[14]) ists_q <= 1'b0;
            if (wr_misc) pde_q <= bus_wdata[0];
        end
    end

    // reset cause survives the system reset; cleared only at power-on
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        rsr_q <= 2'b00;
        else if (sw_rst_q) rsr_q <= 2'b01;
        else if (expire)   rsr_q <= 2'b10;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = {wt_q, wdw_q, 1'b0, wda_q, 1'b1, wdt_q, wde_q, dbg_en_q, lp_en_q};
            OFS_RSR:  bus_rdata = {14'b0, rsr_q};
            OFS_ICR:  bus_rdata = {ie_q, ists_q, 6'b0, wict_q};
            OFS_MISC: bus_rdata = {15'b0, pde_q};
            default:  bus_rdata = '0;
        endcase
    end

    always_comb begin
        tout_rst_o   = expired;
        sw_rst_o     = sw_rst_q;
        irq_o        = ists_q && ie_q;
        wdog_pin_n_o = wda_q && !(expired && wdt_q);
    end

    wdog_svc u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (wr_svc),
        .svc_data (bus_wdata),
        .svc_ok   (svc_ok)
    );

    wdog_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .hold     (hold),
        .load     (load),
        .wdog_on  (wde_nx),
        .load_val (bus_wdata[TB_HI:TB_LO] & {CNT_W{wr_ctrl}} | wt_q & {CNT_W{!wr_ctrl}}),
        .pre_val  (wict_q),
        .pre_hit  (pre_hit),
        .expire   (expire),
        .expired  (expired)
    );

    // R2: enable cannot be cleared once set
    assert_enable_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wde_q |=> wde_q);
    // R9: software reset lasts exactly one cycle
    assert_swrst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_o |=> !sw_rst_o);
    // R8: interrupt only with enable set
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ie_q);
    // R10: at most one reset cause recorded
    assert_one_cause_R10: assert property (@(posedge clk) disable iff (!por_n)
        $countones(rsr_q) <= 1);
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0, por_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic tick_en = 1'b0, dbg_halt_i = 1'b0, low_pwr_i = 1'b0, wait_i = 1'b0;
    logic tout_rst_o, sw_rst_o, wdog_pin_n_o, irq_o;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    wdog_top dut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1;
            @(negedge clk); tick_en = 0;
        end
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    // enable word: WT field, bit4 and bit5 kept at 1, plus extra bits
    function automatic logic [15:0] en_word(input logic [7:0] wt, input logic [7:0] extra);
        return {wt, 8'h34 | extra};
    endfunction

    task automatic t_reset_state();
        logic [15:0] v;
        rd(4'h0, v); chk("R1 ctrl", v, 16'h0030);
        rd(4'h6, v); chk("R1 icr", v, 16'h0000);
        rd(4'h8, v); chk("R1 misc", v, 16'h0001);
        chk("R1 outs", {tout_rst_o, sw_rst_o, irq_o, wdog_pin_n_o}, 4'b0001);
    endtask

    task automatic t_timeout();
        logic [15:0] v;
        sys_reset();
        wr(4'h0, en_word(8'd3, 8'h08));
        ticks(3); chk("R3 before", tout_rst_o, 0);
        ticks(1); chk("R3 expire", tout_rst_o, 1);
        chk("R11 pin on expiry", wdog_pin_n_o, 0);
        rd(4'h4, v); chk("R10 cause tout", v, 16'h0002);
        ticks(2); chk("R3 held", tout_rst_o, 1);
        sys_reset();
        rd(4'h4, v); chk("R10 survives rst_n", v, 16'h0002);
        chk("R3 cleared by rst_n", tout_rst_o, 0);
    endtask

    task automatic t_enable_once();
        logic [15:0] v;
        sys_reset();
        wr(4'h0, en_word(8'd5, 8'h00));
        wr(4'h0, 16'h0530);
        rd(4'h0, v); chk("R2 enable sticks", v[2], 1);
    endtask

    task automatic t_service();
        sys_reset();
        wr(4'h0, en_word(8'd3, 8'h00));
        ticks(3);
        wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
        ticks(3); chk("R4 reloaded", tout_rst_o, 0);
        ticks(1); chk("R4 expiry after reload", tout_rst_o, 1);
    endtask

    task automatic t_bad_service();
        sys_reset();
        wr(4'h0, en_word(8'd3, 8'h00));
        ticks(3);
        wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
        ticks(1); chk("R5 wrong middle word", tout_rst_o, 1);
        sys_reset();
        wr(4'h0, en_word(8'd2, 8'h00));
        ticks(2);
        wr(4'h2, 16'hAAAA);
        ticks(1); chk("R5 lone second word", tout_rst_o, 1);
    endtask

    task automatic t_rewrite();
        sys_reset();
        wr(4'h0, en_word(8'd1, 8'h00));
        ticks(1);
        wr(4'h0, en_word(8'd4, 8'h00));
        ticks(4); chk("R6 reload by ctrl", tout_rst_o, 0);
        ticks(1); chk("R6 new timeout", tout_rst_o, 1);
    endtask

    task automatic t_pause();
        sys_reset();
        wr(4'h0, en_word(8'd2, 8'h83));
        dbg_halt_i = 1; ticks(4); dbg_halt_i = 0;
        low_pwr_i = 1;  ticks(4); low_pwr_i = 0;
        wait_i = 1;     ticks(4); wait_i = 0;
        chk("R7 paused", tout_rst_o, 0);
        ticks(2); chk("R7 resumes", tout_rst_o, 0);
        ticks(1); chk("R7 expiry", tout_rst_o, 1);
        sys_reset();
        wr(4'h0, en_word(8'd1, 8'h00));
        dbg_halt_i = 1; ticks(2); dbg_halt_i = 0;
        chk("R7 ungated status", tout_rst_o, 1);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        sys_reset();
        wr(4'h6, 16'h8003);
        wr(4'h0, en_word(8'd5, 8'h00));
        ticks(1); chk("R8 not yet", irq_o, 0);
        ticks(1); chk("R8 irq", irq_o, 1);
        rd(4'h6, v); chk("R8 status", v, 16'hC003);
        wr(4'h6, 16'hC003);
        chk("R8 w1c", irq_o, 0);
    endtask

    task automatic t_swrst();
        logic [15:0] v;
        sys_reset();
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 4'h0; bus_wdata = 16'h0020;
        @(negedge clk); bus_sel = 0; bus_we = 0;
        chk("R9 pulse", sw_rst_o, 1);
        @(negedge clk); chk("R9 one cycle", sw_rst_o, 0);
        rd(4'h4, v); chk("R9 cause sw", v, 16'h0001);
        rd(4'h0, v); chk("R9 bit reads 1", v[4], 1);
    endtask

    task automatic t_pin_misc();
        logic [15:0] v;
        sys_reset();
        wr(4'h0, 16'h0010);
        chk("R11 pin forced", wdog_pin_n_o, 0);
        wr(4'h8, 16'h0000);
        rd(4'h8, v); chk("R12 misc 0", v, 16'h0000);
        wr(4'h8, 16'h0001);
        rd(4'h8, v); chk("R12 misc 1", v, 16'h0001);
        @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
        rd(4'h4, v); chk("R10 por clears", v, 16'h0000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1; por_n = 1;
                t_reset_state();
                t_timeout();
                t_enable_once();
                t_service();
                t_bad_service();
                t_rewrite();
                t_pause();
                t_irq();
                t_swrst();
                t_pin_misc();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule